// File: doc/BRIEF.md
# Secure Configuration Key Controller

This block guards the volatile decryption key used by a cipher-block-chaining decryptor that sits downstream, and decides whether each incoming configuration stream may be taken. New key material can arrive only through a narrow instruction and serial-shift port, and only after a key-load instruction has moved the block into its key-loading state. Taking that state wipes the stored key at once, so nothing that was there before can ever leak. No path reads the key back. The only place the key goes is a dedicated output to the decryptor, and that output is zero whenever no complete key is held.

Each configuration stream begins with a header that marks it as plain or encrypted. A plain stream is always taken. An encrypted stream is taken only while a complete key is held; otherwise it is refused and an error flag is raised. When an encrypted stream finishes, the block locks and refuses every further header. The lock is released only by a program-pin pulse, a power-on reset, or one of two restart instructions. A tamper alarm or a loss of supply to the key store erases the key in the next cycle.

Top module: `cfg_key_guard`

## Requirements
- R1: After reset, key_valid, locked, cfg_error, hdr_ack, hdr_nak and dec_key are all zero.
- R2: The key-load instruction (code 4'h1) is taken only when the block is idle and no stream is in progress. One cycle after it is taken, key_valid is low and dec_key is zero.
- R3: In the key-loading state, each cycle with shift_en high shifts shift_bit in. The first bit shifted lands in dec_key bit 0, the next in bit 1, and so on. Shifts after KEY_W bits have arrived are ignored. After KEY_W shifts, any instruction other than 4'h1 (for example the exit code 4'h2) or a prog_pulse ends loading, and key_valid then goes high.
- R4: If loading ends with fewer than KEY_W shifts, the key stays all zero and key_valid stays low.
- R5: shift_en and shift_bit have no effect on the key outside the key-loading state.
- R6: A tamper or key_pwr_fail pulse clears the key, and key_valid is low in the next cycle. In the key-loading state it also returns the block to idle.
- R7: A plain header (hdr_encrypted = 0) presented while idle with no stream in progress is accepted whether or not a key is present. hdr_ack then pulses for one cycle and stream_encrypted is low. hdr_ack and hdr_nak are never high together.
- R8: An encrypted header presented while key_valid is low is refused. hdr_nak pulses for one cycle and cfg_error goes high. cfg_error stays high until the next header is accepted.
- R9: An encrypted header presented while a key is held is accepted with stream_encrypted high. The cfg_done that ends that stream raises locked.
- R10: While locked, every header is refused and the key-load instruction is ignored; the key and key_valid stay unchanged.
- R11: locked falls only on prog_pulse, on reset, or on restart codes 4'h3 and 4'h4. cfg_done and other instruction codes leave it set.
- R12: A header that arrives while a stream is still in progress is refused with hdr_nak.
- R13: dec_key is all zero whenever key_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| instr_valid | input | 1 | Instruction strobe |
| instr_code | input | IR_W | Instruction code |
| shift_en | input | 1 | Shift one key bit this cycle |
| shift_bit | input | 1 | Serial key bit |
| hdr_valid | input | 1 | Stream header present this cycle |
| hdr_encrypted | input | 1 | Header marks the stream as encrypted |
| cfg_done | input | 1 | Current stream has ended |
| prog_pulse | input | 1 | Program-pin restart pulse |
| tamper | input | 1 | Tamper alarm, erases the key |
| key_pwr_fail | input | 1 | Key store supply lost, erases the key |
| key_valid | output | 1 | A complete key is held |
| dec_key | output | KEY_W | Key to the decryptor, zero when not valid |
| locked | output | 1 | Encrypted image loaded, new streams refused |
| stream_encrypted | output | 1 | Accepted stream needs decryption |
| hdr_ack | output | 1 | Header accepted (one-cycle pulse) |
| hdr_nak | output | 1 | Header refused (one-cycle pulse) |
| cfg_error | output | 1 | Last header was refused |

## Verification
The bench builds the block with KEY_W = 16 and the default instruction codes. A full key load then takes only sixteen shifts, so full, short and over-long loads can all be run many times. Bit ordering, saturation after the last bit, and erasure in the middle of a load are each checked against a known pattern on dec_key. With the loads this short, every lock and unlock path and every refusal path fits into one scripted table, followed by directed tests for reset and the corner cases.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_KEYACC = 2'd1,
        ST_LOCKED = 2'd2
    } guard_state_e;

    // decoded instruction events for one cycle
    typedef struct packed {
        logic enter;    // key-load request
        logic restart;  // one of the two restart codes
        logic other;    // any valid code except key-load
    } cmd_t;

endpackage

// File: rtl/cfg_instr_decode.sv
module cfg_instr_decode
    import cfg_key_pkg::*;
#(
    parameter int unsigned IR_W       = 4,
    parameter int unsigned CODE_ENTER = 1,
    parameter int unsigned CODE_RST_A = 3,
    parameter int unsigned CODE_RST_B = 4
) (
    input  logic            instr_valid,
    input  logic [IR_W-1:0] instr_code,
    output cmd_t            cmd
);

    localparam logic [IR_W-1:0] ENTER_C = IR_W'(CODE_ENTER);
    localparam logic [IR_W-1:0] RST_A_C = IR_W'(CODE_RST_A);
    localparam logic [IR_W-1:0] RST_B_C = IR_W'(CODE_RST_B);

    always_comb begin
        cmd         = '0;
        cmd.enter   = instr_valid && (instr_code == ENTER_C);
        cmd.restart = instr_valid && ((instr_code == RST_A_C) || (instr_code == RST_B_C));
        cmd.other   = instr_valid && (instr_code != ENTER_C);
    end

endmodule

// File: rtl/cfg_key_store.sv
module cfg_key_store #(
    parameter int unsigned KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             shift,
    input  logic             shift_bit,
    input  logic             finish,
    output logic             key_valid,
    output logic [KEY_W-1:0] dec_key
);

    localparam int unsigned CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_W);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } ks_t;

    ks_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (erase) begin
            s_d = '0;
        end else if (finish) begin
            if (s_q.cnt == FULL) begin
                s_d.valid = 1'b1;
            end else begin
                s_d.key   = '0;
                s_d.valid = 1'b0;
            end
            s_d.cnt = '0;
        end else if (shift && (s_q.cnt != FULL)) begin
            // first bit in ends up at position 0 after KEY_W shifts
            s_d.key = {shift_bit, s_q.key[KEY_W-1:1]};
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign key_valid = s_q.valid;
    assign dec_key   = s_q.valid ? s_q.key : '0;

    a_r2_erase_clears : assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (!s_q.valid && (s_q.cnt == '0)));

    a_r4_short_load : assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !erase && (s_q.cnt != FULL)) |=> !s_q.valid);

    a_r3_full_load : assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !erase && (s_q.cnt == FULL)) |=> s_q.valid);

endmodule

// File: rtl/cfg_guard_fsm.sv
module cfg_guard_fsm
    import cfg_key_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic shift_en,
    input  logic hdr_valid,
    input  logic hdr_encrypted,
    input  logic cfg_done,
    input  logic prog_pulse,
    input  logic kill,
    input  logic key_valid,
    output logic key_erase,
    output logic key_shift,
    output logic key_finish,
    output logic locked,
    output logic stream_encrypted,
    output logic hdr_ack,
    output logic hdr_nak,
    output logic cfg_error
);

    typedef struct packed {
        guard_state_e state;
        logic         busy;
        logic         enc;
        logic         err;
        logic         ack;
        logic         nak;
    } fsm_t;

    fsm_t f_q, f_d;
    logic restart_evt;
    logic entering;
    logic hdr_ok;

    assign restart_evt = cmd.restart | prog_pulse;

    always_comb begin
        f_d        = f_q;
        f_d.ack    = 1'b0;
        f_d.nak    = 1'b0;
        key_erase  = kill;
        key_finish = 1'b0;
        key_shift  = 1'b0;
        entering   = 1'b0;

        unique case (f_q.state)
            ST_IDLE: begin
                if (restart_evt) begin
                    f_d.busy = 1'b0;
                    f_d.enc  = 1'b0;
                end else if (cmd.enter && !f_q.busy) begin
                    entering  = 1'b1;
                    key_erase = 1'b1;
                    f_d.state = ST_KEYACC;
                end else if (cfg_done && f_q.busy) begin
                    f_d.busy = 1'b0;
                    f_d.enc  = 1'b0;
                    if (f_q.enc) f_d.state = ST_LOCKED;
                end
            end
            ST_KEYACC: begin
                if (kill) begin
                    f_d.state = ST_IDLE;
                end else if (cmd.other || prog_pulse) begin
                    key_finish = 1'b1;
                    f_d.state  = ST_IDLE;
                end else begin
                    key_shift = shift_en;
                end
            end
            ST_LOCKED: begin
                if (restart_evt) f_d.state = ST_IDLE;
            end
            default: f_d.state = ST_IDLE;
        endcase

        hdr_ok = (f_q.state == ST_IDLE) && !f_q.busy && !entering
                 && !(hdr_encrypted && !key_valid);
        if (hdr_valid) begin
            if (hdr_ok) begin
                f_d.busy = 1'b1;
                f_d.enc  = hdr_encrypted;
                f_d.err  = 1'b0;
                f_d.ack  = 1'b1;
            end else begin
                f_d.err  = 1'b1;
                f_d.nak  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.state <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign locked           = (f_q.state == ST_LOCKED);
    assign stream_encrypted = f_q.enc;
    assign hdr_ack          = f_q.ack;
    assign hdr_nak          = f_q.nak;
    assign cfg_error        = f_q.err;

    a_r10_lock_holds : assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.state == ST_LOCKED) && !restart_evt) |=> (f_q.state == ST_LOCKED));

    a_r11_unlock_cause : assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.state != ST_LOCKED) && ($past(f_q.state) == ST_LOCKED)) |-> $past(restart_evt));

    a_r8_enc_refused : assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_encrypted && !key_valid) |=> (f_q.nak && f_q.err));

    a_r12_busy_refused : assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && f_q.busy) |=> f_q.nak);

    a_r7_ack_nak_excl : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({f_q.ack, f_q.nak}));

endmodule

// File: rtl/cfg_key_guard.sv
module cfg_key_guard
    import cfg_key_pkg::*;
#(
    parameter int unsigned KEY_W      = 256,
    parameter int unsigned IR_W       = 4,
    parameter int unsigned CODE_ENTER = 1,
    parameter int unsigned CODE_RST_A = 3,
    parameter int unsigned CODE_RST_B = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [IR_W-1:0]  instr_code,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             hdr_valid,
    input  logic             hdr_encrypted,
    input  logic             cfg_done,
    input  logic             prog_pulse,
    input  logic             tamper,
    input  logic             key_pwr_fail,
    output logic             key_valid,
    output logic [KEY_W-1:0] dec_key,
    output logic             locked,
    output logic             stream_encrypted,
    output logic             hdr_ack,
    output logic             hdr_nak,
    output logic             cfg_error
);

    cmd_t cmd;
    logic kill;
    logic key_erase;
    logic key_shift;
    logic key_finish;

    assign kill = tamper | key_pwr_fail;

    cfg_instr_decode #(
        .IR_W       (IR_W),
        .CODE_ENTER (CODE_ENTER),
        .CODE_RST_A (CODE_RST_A),
        .CODE_RST_B (CODE_RST_B)
    ) u_dec (
        .instr_valid (instr_valid),
        .instr_code  (instr_code),
        .cmd         (cmd)
    );

    cfg_guard_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd              (cmd),
        .shift_en         (shift_en),
        .hdr_valid        (hdr_valid),
        .hdr_encrypted    (hdr_encrypted),
        .cfg_done         (cfg_done),
        .prog_pulse       (prog_pulse),
        .kill             (kill),
        .key_valid        (key_valid),
        .key_erase        (key_erase),
        .key_shift        (key_shift),
        .key_finish       (key_finish),
        .locked           (locked),
        .stream_encrypted (stream_encrypted),
        .hdr_ack          (hdr_ack),
        .hdr_nak          (hdr_nak),
        .cfg_error        (cfg_error)
    );

    cfg_key_store #(
        .KEY_W (KEY_W)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (key_erase),
        .shift     (key_shift),
        .shift_bit (shift_bit),
        .finish    (key_finish),
        .key_valid (key_valid),
        .dec_key   (dec_key)
    );

    a_r6_kill_erases : assert property (@(posedge clk) disable iff (!rst_n)
        (tamper || key_pwr_fail) |=> (!key_valid && (dec_key == '0)));

    a_r13_no_stale_key : assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !$past(key_valid)) |-> (dec_key == '0));

endmodule

// File: tb/test_cfg_key_guard.sv
module test_cfg_key_guard;

    localparam int KW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [3:0]    instr_code = '0;
    logic          shift_en = 1'b0;
    logic          shift_bit = 1'b0;
    logic          hdr_valid = 1'b0;
    logic          hdr_encrypted = 1'b0;
    logic          cfg_done = 1'b0;
    logic          prog_pulse = 1'b0;
    logic          tamper = 1'b0;
    logic          key_pwr_fail = 1'b0;
    logic          key_valid;
    logic [KW-1:0] dec_key;
    logic          locked;
    logic          stream_encrypted;
    logic          hdr_ack;
    logic          hdr_nak;
    logic          cfg_error;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_key_guard #(.KEY_W(KW)) i_cfg_key_guard (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_code (instr_code),
        .shift_en (shift_en), .shift_bit (shift_bit), .hdr_valid (hdr_valid),
        .hdr_encrypted (hdr_encrypted), .cfg_done (cfg_done), .prog_pulse (prog_pulse),
        .tamper (tamper), .key_pwr_fail (key_pwr_fail), .key_valid (key_valid),
        .dec_key (dec_key), .locked (locked), .stream_encrypted (stream_encrypted),
        .hdr_ack (hdr_ack), .hdr_nak (hdr_nak), .cfg_error (cfg_error)
    );

    // op codes of the scripted table
    localparam logic [2:0] OP_HDR = 3'd0, OP_DONE = 3'd1, OP_LOAD = 3'd2, OP_SHORT = 3'd3,
                           OP_INS = 3'd4, OP_PROG = 3'd5, OP_TAMP = 3'd6;
    // row: {op, arg, requirement number, key_valid, locked, cfg_error}
    localparam int NROW = 20;
    localparam logic [25:0] VEC [0:NROW-1] = '{
        {OP_HDR,   16'h0001, 4'd8,  3'b001}, // R8 encrypted, no key
        {OP_HDR,   16'h0000, 4'd7,  3'b000}, // R7 plain, no key
        {OP_DONE,  16'h0000, 4'd7,  3'b000}, // R7 plain done, no lock
        {OP_LOAD,  16'hA5C3, 4'd3,  3'b100}, // R3 full load
        {OP_HDR,   16'h0001, 4'd9,  3'b100}, // R9 encrypted accepted
        {OP_DONE,  16'h0000, 4'd9,  3'b110}, // R9 lock
        {OP_HDR,   16'h0000, 4'd10, 3'b111}, // R10 refused while locked
        {OP_INS,   16'h0003, 4'd11, 3'b101}, // R11 restart code A
        {OP_HDR,   16'h0001, 4'd9,  3'b100}, // R9
        {OP_DONE,  16'h0000, 4'd9,  3'b110}, // R9
        {OP_PROG,  16'h0000, 4'd11, 3'b100}, // R11 program pulse
        {OP_SHORT, 16'h0005, 4'd4,  3'b000}, // R4 short load
        {OP_HDR,   16'h0001, 4'd8,  3'b001}, // R8
        {OP_LOAD,  16'h1234, 4'd3,  3'b101}, // R3
        {OP_HDR,   16'h0001, 4'd9,  3'b100}, // R9
        {OP_DONE,  16'h0000, 4'd9,  3'b110}, // R9
        {OP_INS,   16'h0004, 4'd11, 3'b100}, // R11 restart code B
        {OP_TAMP,  16'h0000, 4'd6,  3'b000}, // R6 tamper
        {OP_HDR,   16'h0000, 4'd7,  3'b000}, // R7
        {OP_DONE,  16'h0000, 4'd7,  3'b000}  // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_instr(input logic [3:0] code);
        instr_valid = 1'b1; instr_code = code;
        cyc();
        instr_valid = 1'b0; instr_code = '0;
    endtask

    task automatic do_hdr(input logic enc);
        hdr_valid = 1'b1; hdr_encrypted = enc;
        cyc();
        hdr_valid = 1'b0; hdr_encrypted = 1'b0;
    endtask

    task automatic do_done();
        cfg_done = 1'b1; cyc(); cfg_done = 1'b0;
    endtask

    task automatic do_prog();
        prog_pulse = 1'b1; cyc(); prog_pulse = 1'b0;
    endtask

    task automatic do_tamper();
        tamper = 1'b1; cyc(); tamper = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] val, input int n);
        for (int i = 0; i < n; i++) begin
            shift_en = 1'b1; shift_bit = val[i];
            cyc();
        end
        shift_en = 1'b0; shift_bit = 1'b0;
    endtask

    task automatic load_key(input logic [31:0] val, input int n);
        do_instr(4'h1);
        shift_bits(val, n);
        do_instr(4'h2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1 key_valid in reset", key_valid, 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 key_valid", key_valid, 0);
        chk("R1 locked", locked, 0);
        chk("R1 cfg_error", cfg_error, 0);
        chk("R1 ack/nak", {hdr_ack, hdr_nak}, 0);
        chk("R1 dec_key", dec_key, 0);

        for (int r = 0; r < NROW; r++) begin
            logic [2:0]  op;
            logic [15:0] arg;
            logic [3:0]  req;
            op  = VEC[r][25:23];
            arg = VEC[r][22:7];
            req = VEC[r][6:3];
            case (op)
                OP_HDR:   do_hdr(arg[0]);
                OP_DONE:  do_done();
                OP_LOAD:  load_key({16'h0, arg}, KW);
                OP_SHORT: load_key(32'hFFFF_FFFF, int'(arg));
                OP_INS:   do_instr(arg[3:0]);
                OP_PROG:  do_prog();
                default:  do_tamper();
            endcase
            chk($sformatf("R%0d row %0d key_valid", req, r), key_valid, VEC[r][2]);
            chk($sformatf("R%0d row %0d locked", req, r), locked, VEC[r][1]);
            chk($sformatf("R%0d row %0d cfg_error", req, r), cfg_error, VEC[r][0]);
            if (op == OP_SHORT)
                chk("R13 dec_key zero after short load", dec_key, 0);
        end

        // R3 bit order
        load_key(32'h0000_A5C3, KW);
        chk("R3 dec_key after load", dec_key, 16'hA5C3);
        // R5 shifts outside key-loading state
        shift_bits(32'h0000_000F, 4);
        chk("R5 dec_key unchanged", dec_key, 16'hA5C3);
        chk("R5 key_valid unchanged", key_valid, 1);
        // R2 entry erases
        do_instr(4'h1);
        chk("R2 key_valid after entry", key_valid, 0);
        chk("R13 dec_key after entry", dec_key, 0);
        // R3 extra shifts ignored
        shift_bits(32'h000F_3C96, 20);
        do_instr(4'h2);
        chk("R3 saturated load", dec_key, 16'h3C96);
        chk("R3 key_valid", key_valid, 1);

        // R7 / R12
        hdr_valid = 1'b1; hdr_encrypted = 1'b0;
        cyc();
        hdr_valid = 1'b0;
        chk("R7 hdr_ack", hdr_ack, 1);
        chk("R7 stream_encrypted", stream_encrypted, 0);
        do_hdr(1'b0);
        chk("R12 hdr_nak while busy", hdr_nak, 1);
        chk("R12 hdr_ack while busy", hdr_ack, 0);
        do_done();

        // R9 / R10 / R11
        do_hdr(1'b1);
        chk("R9 stream_encrypted", stream_encrypted, 1);
        do_done();
        chk("R9 locked", locked, 1);
        do_instr(4'h1);
        chk("R10 key kept", dec_key, 16'h3C96);
        chk("R10 key_valid kept", key_valid, 1);
        do_done();
        do_instr(4'h7);
        chk("R11 still locked", locked, 1);
        do_prog();
        chk("R11 unlocked by pulse", locked, 0);

        // R6 supply loss mid-load
        do_instr(4'h1);
        shift_bits(32'h0000_00FF, 8);
        key_pwr_fail = 1'b1; cyc(); key_pwr_fail = 1'b0;
        chk("R6 key_valid after supply loss", key_valid, 0);
        do_hdr(1'b0);
        chk("R6 idle after supply loss", hdr_ack, 1);
        do_done();

        // R1 / R11 reset releases lock and key
        load_key(32'h0000_5A5A, KW);
        do_hdr(1'b1);
        do_done();
        chk("R11 locked before reset", locked, 1);
        rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
        chk("R11 locked after reset", locked, 0);
        chk("R1 key_valid after reset", key_valid, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule